// File: doc/BRIEF.md
# Defect Recovery Action Controller

This block is the single decision point that turns defect-match requests into a recovery sequence. Several detectors, spread over the chip and gathered through hub units, each raise a level request with three facts about it: whether the match was seen before or after the defect took effect, whether the damage stays inside one module, and which module that is. The controller takes one request at a time and decides what to do. A later global checkpoint capability flag then chooses between rolling back and interrupting the operating system.

A request seen before the defect is handled by switching the triggering condition off so execution continues. A request seen after the defect always begins with a pipeline flush. The flush is followed by a reset of the one affected module, a rollback to the last checkpoint, or an interrupt to the operating system. Every command is a request/done handshake with the agent that carries it out. The controller stays busy until the last handshake of a sequence ends. It records which action finished the sequence and which detector caused it.

Top module: `rcv_ctrl`

## Requirements
- R1: After reset, busy, every grant and every command request are low, and both status outputs read zero.
- R2: When requests are pending and the controller is idle, exactly one grant bit pulses for one cycle, and it belongs to the lowest-indexed pending requester.
- R3: A request that is not granted stays pending and is served later, in ascending index order, with no request lost.
- R4: A before-defect request (its det_post bit low) produces only the condition-off handshake, with no flush.
- R5: An after-defect request (det_post bit high) starts with the flush handshake, and no other command starts before the flush is done.
- R6: After the flush, a local after-defect request (det_local bit high) resets its module, and mod_rst_tgt carries that requester's det_mod field.
- R7: After the flush, a non-local after-defect request rolls back to the checkpoint when ckpt_avail is high.
- R8: After the flush, a non-local after-defect request interrupts the operating system when ckpt_avail is low.
- R9: Each command request stays high until its done input is seen. Busy covers the whole sequence, and no grant is issued while busy.
- R10: A done input whose command is not active has no effect on state, commands or status.
- R11: When a sequence completes, stat_action takes the final action code (1 condition-off, 2 module reset, 3 rollback, 4 operating-system interrupt) and stat_src takes the requester index. Both hold until the next completion.
- R12: ckpt_avail is sampled in the cycle a request is accepted, so later changes do not alter that request's path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_valid | input | NUM_SRC | Level request per detector, held until granted |
| det_post | input | NUM_SRC | 1 = match seen after the defect took effect |
| det_local | input | NUM_SRC | 1 = effect confined to one module |
| det_mod | input | NUM_SRC*MOD_W | Affected module id per detector, detector i at bits i*MOD_W |
| ckpt_avail | input | 1 | Platform has checkpoint support |
| det_grant | output | NUM_SRC | One-cycle acceptance pulse per detector |
| busy | output | 1 | A recovery sequence is in progress |
| cond_off_req | output | 1 | Switch the triggering condition off |
| cond_off_done | input | 1 | Condition-off complete |
| flush_req | output | 1 | Flush the pipeline |
| flush_done | input | 1 | Flush complete |
| mod_rst_req | output | 1 | Reset the affected module |
| mod_rst_tgt | output | MOD_W | Module to reset |
| mod_rst_done | input | 1 | Module reset complete |
| rollback_req | output | 1 | Roll back to checkpoint |
| rollback_done | input | 1 | Rollback complete |
| os_irq_req | output | 1 | Interrupt the operating system |
| os_irq_done | input | 1 | Interrupt taken |
| stat_action | output | 3 | Final action of the last completed sequence |
| stat_src | output | IDX_W | Requester of the last completed sequence |

## Verification
The hardest situation to reach is a new request arriving, together with stray done pulses on idle command lines, while a flush is held open. From the ports this needs a completion agent that can withhold its answer. The bench's responder has a hold switch. The bench holds the flush of one request open, raises a lower-indexed request during the hold, and pulses every other done line. It then confirms that the flush stays the only active command and that the waiting request is granted only after the whole first sequence ends. A second held case flips ckpt_avail after acceptance to show that the path chosen at acceptance stands.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  typedef enum logic [2:0] {
    ACT_NONE     = 3'd0,
    ACT_COND_OFF = 3'd1,
    ACT_MOD_RST  = 3'd2,
    ACT_ROLLBACK = 3'd3,
    ACT_OS_IRQ   = 3'd4
  } rcv_action_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COND_OFF,
    ST_FLUSH,
    ST_MOD_RST,
    ST_ROLLBACK,
    ST_OS_IRQ
  } rcv_state_e;

endpackage

// File: rtl/rcv_arbiter.sv
module rcv_arbiter #(
  parameter int NUM_SRC = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_SRC-1:0] valid,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] onehot
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (valid[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
    onehot = '0;
    if (any) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/rcv_policy.sv
module rcv_policy
  import rcv_pkg::*;
(
  input  logic        post,
  input  logic        local_fx,
  input  logic        ckpt,
  output rcv_action_e action
);
  always_comb begin
    if (!post)         action = ACT_COND_OFF;
    else if (local_fx) action = ACT_MOD_RST;
    else if (ckpt)     action = ACT_ROLLBACK;
    else               action = ACT_OS_IRQ;
  end
endmodule

// File: rtl/rcv_sequencer.sv
module rcv_sequencer
  import rcv_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int MOD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  rcv_action_e       start_action,
  input  logic [MOD_W-1:0]  start_mod,
  input  logic              cond_off_done,
  input  logic              flush_done,
  input  logic              mod_rst_done,
  input  logic              rollback_done,
  input  logic              os_irq_done,
  output logic              busy,
  output logic              cond_off_req,
  output logic              flush_req,
  output logic              mod_rst_req,
  output logic [MOD_W-1:0]  mod_rst_tgt,
  output logic              rollback_req,
  output logic              os_irq_req,
  output logic [2:0]        stat_action,
  output logic [IDX_W-1:0]  stat_src
);
  rcv_state_e        state;
  rcv_action_e       act_q;
  logic [IDX_W-1:0]  src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      act_q        <= ACT_NONE;
      src_q        <= '0;
      mod_rst_tgt  <= '0;
      busy         <= 1'b0;
      cond_off_req <= 1'b0;
      flush_req    <= 1'b0;
      mod_rst_req  <= 1'b0;
      rollback_req <= 1'b0;
      os_irq_req   <= 1'b0;
      stat_action  <= 3'd0;
      stat_src     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            src_q       <= start_idx;
            act_q       <= start_action;
            mod_rst_tgt <= start_mod;
            busy        <= 1'b1;
            if (start_action == ACT_COND_OFF) begin
              state        <= ST_COND_OFF;
              cond_off_req <= 1'b1;
            end else begin
              state     <= ST_FLUSH;
              flush_req <= 1'b1;
            end
          end
        end
        ST_COND_OFF: begin
          if (cond_off_done) begin
            cond_off_req <= 1'b0;
            state        <= ST_IDLE;
            busy         <= 1'b0;
            stat_action  <= act_q;
            stat_src     <= src_q;
          end
        end
        ST_FLUSH: begin
          if (flush_done) begin
            flush_req <= 1'b0;
            case (act_q)
              ACT_MOD_RST: begin
                state       <= ST_MOD_RST;
                mod_rst_req <= 1'b1;
              end
              ACT_ROLLBACK: begin
                state        <= ST_ROLLBACK;
                rollback_req <= 1'b1;
              end
              default: begin
                state      <= ST_OS_IRQ;
                os_irq_req <= 1'b1;
              end
            endcase
          end
        end
        ST_MOD_RST: begin
          if (mod_rst_done) begin
            mod_rst_req <= 1'b0;
            state       <= ST_IDLE;
            busy        <= 1'b0;
            stat_action <= act_q;
            stat_src    <= src_q;
          end
        end
        ST_ROLLBACK: begin
          if (rollback_done) begin
            rollback_req <= 1'b0;
            state        <= ST_IDLE;
            busy         <= 1'b0;
            stat_action  <= act_q;
            stat_src     <= src_q;
          end
        end
        ST_OS_IRQ: begin
          if (os_irq_done) begin
            os_irq_req  <= 1'b0;
            state       <= ST_IDLE;
            busy        <= 1'b0;
            stat_action <= act_q;
            stat_src    <= src_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rcv_ctrl.sv
module rcv_ctrl
  import rcv_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int MOD_W   = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       det_valid,
  input  logic [NUM_SRC-1:0]       det_post,
  input  logic [NUM_SRC-1:0]       det_local,
  input  logic [NUM_SRC*MOD_W-1:0] det_mod,
  input  logic                     ckpt_avail,
  output logic [NUM_SRC-1:0]       det_grant,
  output logic                     busy,
  output logic                     cond_off_req,
  input  logic                     cond_off_done,
  output logic                     flush_req,
  input  logic                     flush_done,
  output logic                     mod_rst_req,
  output logic [MOD_W-1:0]         mod_rst_tgt,
  input  logic                     mod_rst_done,
  output logic                     rollback_req,
  input  logic                     rollback_done,
  output logic                     os_irq_req,
  input  logic                     os_irq_done,
  output logic [2:0]               stat_action,
  output logic [IDX_W-1:0]         stat_src
);
  logic               win_any;
  logic [IDX_W-1:0]   win_idx;
  logic [NUM_SRC-1:0] win_onehot;
  logic [MOD_W-1:0]   mod_arr [NUM_SRC];
  logic               sel_post, sel_local;
  logic [MOD_W-1:0]   sel_mod;
  rcv_action_e        sel_action;
  logic               start;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_mod
      assign mod_arr[g] = det_mod[g*MOD_W +: MOD_W];
    end
  endgenerate

  rcv_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
    .valid  (det_valid),
    .any    (win_any),
    .idx    (win_idx),
    .onehot (win_onehot)
  );

  assign sel_post  = det_post[win_idx];
  assign sel_local = det_local[win_idx];
  assign sel_mod   = mod_arr[win_idx];

  rcv_policy pol_i (
    .post     (sel_post),
    .local_fx (sel_local),
    .ckpt     (ckpt_avail),
    .action   (sel_action)
  );

  assign start = win_any && !busy;

  always_ff @(posedge clk) begin
    if (rst) det_grant <= '0;
    else     det_grant <= start ? win_onehot : '0;
  end

  rcv_sequencer #(.IDX_W(IDX_W), .MOD_W(MOD_W)) seq_i (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .start_idx     (win_idx),
    .start_action  (sel_action),
    .start_mod     (sel_mod),
    .cond_off_done (cond_off_done),
    .flush_done    (flush_done),
    .mod_rst_done  (mod_rst_done),
    .rollback_done (rollback_done),
    .os_irq_done   (os_irq_done),
    .busy          (busy),
    .cond_off_req  (cond_off_req),
    .flush_req     (flush_req),
    .mod_rst_req   (mod_rst_req),
    .mod_rst_tgt   (mod_rst_tgt),
    .rollback_req  (rollback_req),
    .os_irq_req    (os_irq_req),
    .stat_action   (stat_action),
    .stat_src      (stat_src)
  );
endmodule

// File: rtl/rcv_ctrl_chk.sv
module rcv_ctrl_chk #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] det_valid,
  input logic [NUM_SRC-1:0] det_grant,
  input logic               busy,
  input logic               cond_off_req,
  input logic               flush_req,
  input logic               mod_rst_req,
  input logic               rollback_req,
  input logic               os_irq_req,
  input logic               cond_off_done,
  input logic               flush_done,
  input logic               mod_rst_done,
  input logic               rollback_done,
  input logic               os_irq_done
);
  logic [4:0] reqs, dones;
  assign reqs  = {os_irq_req, rollback_req, mod_rst_req, flush_req, cond_off_req};
  assign dones = {os_irq_done, rollback_done, mod_rst_done, flush_done, cond_off_done};

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(det_grant));

  assert_grant_pending_R2: assert property (@(posedge clk) disable iff (rst)
    (|det_grant) |-> ((det_grant & ~$past(det_valid)) == '0));

  assert_one_command_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqs));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    ((reqs & ~dones) != 5'd0) |=> ((reqs & $past(reqs & ~dones)) == $past(reqs & ~dones)));

  assert_busy_covers_R9: assert property (@(posedge clk) disable iff (rst)
    (|reqs) |-> busy);

  assert_no_grant_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (|det_grant) |-> !$past(busy));

  assert_flush_first_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mod_rst_req) || $rose(rollback_req) || $rose(os_irq_req)) |-> $past(flush_req));
endmodule

bind rcv_ctrl rcv_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .det_valid     (det_valid),
  .det_grant     (det_grant),
  .busy          (busy),
  .cond_off_req  (cond_off_req),
  .flush_req     (flush_req),
  .mod_rst_req   (mod_rst_req),
  .rollback_req  (rollback_req),
  .os_irq_req    (os_irq_req),
  .cond_off_done (cond_off_done),
  .flush_done    (flush_done),
  .mod_rst_done  (mod_rst_done),
  .rollback_done (rollback_done),
  .os_irq_done   (os_irq_done)
);

// File: tb/rcv_ctrl_tb_top.sv
module rcv_ctrl_tb_top;
  localparam int N  = 4;
  localparam int MW = 4;
  localparam int IW = 2;
  // vector: [12:9] valid mask, [8:5] post, [4:1] local, [0] ckpt
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    13'b0001_0000_0000_0,
    13'b0010_0010_0010_0,
    13'b0100_0100_0000_1,
    13'b1000_1000_0000_0,
    13'b1111_1010_0010_1,
    13'b1100_1100_0000_0,
    13'b0110_0100_0100_0,
    13'b1001_1001_0000_1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]    det_valid = '0, det_post = '0, det_local = '0;
  logic [N*MW-1:0] det_mod;
  logic            ckpt_avail = 1'b0;
  logic [N-1:0]    det_grant;
  logic            busy, cond_off_req, flush_req, mod_rst_req, rollback_req, os_irq_req;
  logic [MW-1:0]   mod_rst_tgt;
  logic [2:0]      stat_action;
  logic [IW-1:0]   stat_src;
  logic            cond_off_done, flush_done, mod_rst_done, rollback_done, os_irq_done;

  logic       hold_done = 1'b0;
  logic [4:0] force_done = 5'd0;
  logic [4:0] rsp = 5'd0;
  logic [4:0] prev_req = 5'd0;
  int         log_q [256];
  int         lt = 0;
  int         mod_seen = -1;
  int         n_cmp = 0, n_bad = 0;

  for (genvar i = 0; i < N; i++) begin : g_mod
    assign det_mod[i*MW +: MW] = MW'(i * 3 + 1);
  end

  assign cond_off_done = rsp[0] | force_done[0];
  assign flush_done    = rsp[1] | force_done[1];
  assign mod_rst_done  = rsp[2] | force_done[2];
  assign rollback_done = rsp[3] | force_done[3];
  assign os_irq_done   = rsp[4] | force_done[4];

  rcv_ctrl #(.NUM_SRC(N), .MOD_W(MW)) dut_i (.*);

  // completion agent and command recorder (log codes: 1..4 actions, 5 flush)
  always @(negedge clk) begin
    logic [4:0] r;
    r = {os_irq_req, rollback_req, mod_rst_req, flush_req, cond_off_req};
    for (int k = 0; k < 5; k++) begin
      if (r[k] && !prev_req[k]) begin
        log_q[lt % 256] = (k == 0) ? 1 : (k == 1) ? 5 : k;
        lt = lt + 1;
        if (k == 2) mod_seen = int'(mod_rst_tgt);
      end
    end
    prev_req = r;
    for (int k = 0; k < 5; k++) rsp[k] <= r[k] && !rsp[k] && !hold_done;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_act(input bit post, input bit loc, input bit ck);
    if (!post) return 1;
    if (loc) return 2;
    if (ck) return 3;
    return 4;
  endfunction

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic check_seq(input int base, input int ea, input int src);
    int n;
    n = lt - base;
    if (ea == 1) begin
      chk(n == 1, "R4 command count", n, 1);
      chk(log_q[base % 256] == 1, "R4 condition-off only", log_q[base % 256], 1);
    end else begin
      chk(n == 2, "R5 command count", n, 2);
      chk(log_q[base % 256] == 5, "R5 flush first", log_q[base % 256], 5);
      chk(log_q[(base + 1) % 256] == ea, "R6/R7/R8 final action", log_q[(base + 1) % 256], ea);
      if (ea == 2) chk(mod_seen == src * 3 + 1, "R6 module target", mod_seen, src * 3 + 1);
    end
    chk(int'(stat_action) == ea, "R11 status action", int'(stat_action), ea);
    chk(int'(stat_src) == src, "R11 status source", int'(stat_src), src);
  endtask

  task automatic serve_all(input logic [N-1:0] mask, post, loc, input bit ck);
    logic [N-1:0] pending;
    @(negedge clk);
    det_post = post; det_local = loc; ckpt_avail = ck; det_valid = mask;
    pending = mask;
    while (pending != '0) begin
      int e, base, ea;
      e = lowest(pending);
      base = lt;
      do @(negedge clk); while (det_grant == '0);
      chk(det_grant == N'(1 << e), "R2 lowest-index grant", int'(det_grant), 1 << e);
      chk(busy == 1'b1, "R9 busy at grant", int'(busy), 1);
      det_valid = det_valid & ~det_grant;
      pending = pending & ~det_grant;
      do @(negedge clk); while (busy);
      ea = exp_act(post[e], loc[e], ck);
      check_seq(base, ea, e);
    end
    chk(pending == '0, "R3 all pending served", int'(pending), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && det_grant == 0, "R1 idle after reset", int'({busy, det_grant}), 0);
    chk({cond_off_req, flush_req, mod_rst_req, rollback_req, os_irq_req} == 0,
        "R1 no command after reset", 1, 0);
    chk(stat_action == 0 && stat_src == 0, "R1 status cleared", int'(stat_action), 0);

    for (int v = 0; v < NV; v++)
      serve_all(VEC[v][12:9], VEC[v][8:5], VEC[v][4:1], VEC[v][0]);

    // R10 stray done pulses while idle
    @(negedge clk);
    force_done = 5'b11111;
    repeat (3) begin
      @(negedge clk);
      chk(busy == 0, "R10 idle done ignored (busy)", int'(busy), 0);
      chk({cond_off_req, flush_req, mod_rst_req, rollback_req, os_irq_req} == 0,
          "R10 idle done ignored (commands)", 1, 0);
    end
    force_done = 5'd0;
    chk(stat_action == 3 && stat_src == 3, "R11 status held", int'(stat_action), 3);

    // R9/R10: flush held open, new request arrives, stray dones on other lines
    hold_done = 1'b1;
    det_post = 4'b0100; det_local = 4'b0100; ckpt_avail = 1'b0;
    base = lt;
    det_valid = 4'b0100;
    do @(negedge clk); while (det_grant == '0);
    det_valid = 4'b0001;
    repeat (6) begin
      @(negedge clk);
      chk(busy && flush_req, "R9 held while done withheld", int'({busy, flush_req}), 3);
      chk(det_grant == 0, "R9 no grant while busy", int'(det_grant), 0);
    end
    force_done = 5'b11101;
    repeat (2) begin
      @(negedge clk);
      chk(flush_req && !cond_off_req && !mod_rst_req && !rollback_req && !os_irq_req,
          "R10 inactive done ignored", int'({os_irq_req, rollback_req, mod_rst_req, flush_req, cond_off_req}), 2);
    end
    force_done = 5'd0;
    @(negedge clk);
    hold_done = 1'b0;
    do @(negedge clk); while (busy);
    check_seq(base, 2, 2);
    base = lt;
    do @(negedge clk); while (det_grant == '0);
    chk(det_grant == 4'b0001, "R3 waiting request served", int'(det_grant), 1);
    det_valid = '0;
    do @(negedge clk); while (busy);
    check_seq(base, 1, 0);

    // R12 checkpoint flag sampled at acceptance
    det_post = 4'b0010; det_local = 4'b0000; ckpt_avail = 1'b1;
    base = lt;
    det_valid = 4'b0010;
    do @(negedge clk); while (det_grant == '0);
    det_valid = '0; ckpt_avail = 1'b0;
    do @(negedge clk); while (busy);
    chk(stat_action == 3, "R12 rollback kept after flag drop", int'(stat_action), 3);
    base = lt;
    det_valid = 4'b0010;
    do @(negedge clk); while (det_grant == '0);
    det_valid = '0; ckpt_avail = 1'b1;
    do @(negedge clk); while (busy);
    chk(stat_action == 4, "R12 interrupt kept after flag rise", int'(stat_action), 4);
    chk(lt - base == 2, "R12 sequence length", lt - base, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule